// File: doc/BRIEF.md
# Pseudo-DMA Byte-Lane Adapter

This block sits between a processor's pseudo-DMA window and the byte-wide queues of a SCSI controller. The processor issues one access of 1, 2, 3 or 4 bytes. The adapter turns it into one or two single-byte operations on a byte FIFO, one per clock. Wide accesses are split most-significant byte first. Reads put the bytes back together in the same order.

A command-phase input is sampled when an access starts. It steers the bytes either to the command queue or to the data queue. Every byte that is written lowers an external transfer counter. A write that finds the counter already at zero is dropped.

One clock after the last byte operation, the adapter looks at the counter and at the data queue. If the transfer should complete, it raises a single-cycle completion pulse. What the controller does after completion is left to the logic that receives the pulse.

Top module: `pdma_lane_adapter`

## Requirements
- R1: A 2-byte write pushes `acc_wdata[15:8]` in one cycle and `acc_wdata[7:0]` in the next cycle, in that order.
- R2: A 2-byte read places the first byte popped in `acc_rdata[15:8]` and the second in `acc_rdata[7:0]`, and presents them with `acc_rvalid` for one cycle.
- R3: Every byte that is written raises `tc_dec` for exactly one cycle, together with its push strobe.
- R4: A byte write that sees `tc_zero` high produces neither a push nor `tc_dec`.
- R5: If `cmd_phase` is high when an access starts, all its bytes use the command queue (`cq_*`). Otherwise they use the data queue (`dq_*`). The two queues are never strobed in the same cycle.
- R6: After a write access, `xfer_done` fires if `tc_zero` or `dq_full` is high in the cycle after the final byte operation.
- R7: After a read access, `xfer_done` fires if `dq_empty` is high in the cycle after the final byte operation. The command queue's level plays no part in this decision.
- R8: A size of 3 or 4 behaves exactly like a size of 2 on the low 16 bits. A size of 1 uses bits 7:0 only, and a 1-byte read returns zero in bits 15:8.
- R9: A request with a size of 0, or greater than 4, is ignored: no strobe, no `acc_busy`, no completion pulse.
- R10: A read byte whose source queue is empty returns 0x00, and no pop strobe is issued for it.
- R11: `xfer_done` lasts one cycle. It appears in the cycle right after the final byte operation (cycle 1 of a 1-byte access, cycle 2 of a 2-byte access, counted from the first cycle of `acc_busy`).
- R12: After reset, `acc_busy`, `xfer_done`, `acc_rvalid`, `tc_dec` and every queue strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_req | input | 1 | Access request, taken when not busy |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 16 | Write data, low half of the host bus |
| acc_busy | output | 1 | Access in progress |
| acc_rdata | output | 16 | Assembled read data |
| acc_rvalid | output | 1 | Read data valid, one cycle |
| cmd_phase | input | 1 | Route bytes to the command queue |
| dq_push | output | 1 | Data queue push |
| dq_pop | output | 1 | Data queue pop |
| dq_wbyte | output | 8 | Byte to data queue |
| dq_rbyte | input | 8 | Data queue head byte |
| dq_full | input | 1 | Data queue full |
| dq_empty | input | 1 | Data queue empty |
| cq_push | output | 1 | Command queue push |
| cq_pop | output | 1 | Command queue pop |
| cq_wbyte | output | 8 | Byte to command queue |
| cq_rbyte | input | 8 | Command queue head byte |
| cq_empty | input | 1 | Command queue empty |
| tc_dec | output | 1 | Decrement transfer counter |
| tc_zero | input | 1 | Transfer counter is zero |
| xfer_done | output | 1 | Completion pulse |

## Verification
Writes are driven with distinct values in the high and low byte, so a swapped or repeated lane shows up at once in the queue contents. The counter is preset to 1 before one 2-byte write, which separates the byte that is pushed from the byte that is dropped. Reads are run with the data queue holding two bytes, holding three bytes, and holding nothing. These three cases separate byte order, the empty-fill value, and completion on "queue empty" from completion that is missing or fires too early. Command-phase accesses use the same patterns against a command queue that is filled differently from the data queue, so any crossed routing or a completion test on the wrong queue becomes visible. Sizes 0, 3, 4 and 5 check the size decoding.

// File: rtl/pdma_lane_pkg.sv
package pdma_lane_pkg;

   typedef enum logic [1:0] {
      PL_IDLE  = 2'd0,
      PL_XFER  = 2'd1,
      PL_CHECK = 2'd2
   } pl_state_e;

endpackage

// File: rtl/pdma_size_decode.sv
module pdma_size_decode #(
   parameter int SIZE_W        = 3,
   parameter int MAX_ACC_BYTES = 4,
   parameter int WIDE_LANES    = 2,
   parameter int IDX_W         = 1
) (
   input  logic [SIZE_W-1:0] size,
   output logic              size_ok,
   output logic [IDX_W-1:0]  first_lane
);

   always_comb begin
      size_ok = (int'(size) >= 1) && (int'(size) <= MAX_ACC_BYTES);
   end

   generate
      if (WIDE_LANES == 1) begin : g_single
         assign first_lane = '0;
      end else begin : g_multi
         always_comb begin
            int n;
            n = int'(size);
            if (n >= WIDE_LANES) first_lane = IDX_W'(WIDE_LANES - 1);
            else if (n >= 1)     first_lane = IDX_W'(n - 1);
            else                 first_lane = '0;
         end
      end
   endgenerate

endmodule

// File: rtl/pdma_lane_seq.sv
module pdma_lane_seq
   import pdma_lane_pkg::*;
#(
   parameter int IDX_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] first_lane,
   output logic             busy,
   output logic             xfer,
   output logic             check,
   output logic [IDX_W-1:0] lane
);

   pl_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PL_IDLE;
         lane    <= '0;
      end else begin
         unique case (state_q)
            PL_IDLE: begin
               if (start) begin
                  state_q <= PL_XFER;
                  lane    <= first_lane;
               end
            end
            PL_XFER: begin
               if (lane == '0) state_q <= PL_CHECK;
               else            lane    <= lane - 1'b1;
            end
            PL_CHECK: state_q <= PL_IDLE;
            default:  state_q <= PL_IDLE;
         endcase
      end
   end

   assign busy  = (state_q != PL_IDLE);
   assign xfer  = (state_q == PL_XFER);
   assign check = (state_q == PL_CHECK);

endmodule

// File: rtl/pdma_byte_path.sv
module pdma_byte_path #(
   parameter int               BYTE_W     = 8,
   parameter int               WIDE_LANES = 2,
   parameter int               IDX_W      = 1,
   parameter logic [BYTE_W-1:0] EMPTY_FILL = '0,
   localparam int              HOST_W     = WIDE_LANES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              xfer,
   input  logic [IDX_W-1:0]  lane,
   input  logic              wr_in,
   input  logic              cmd_in,
   input  logic [HOST_W-1:0] wdata_in,
   output logic              wr_q,
   output logic [HOST_W-1:0] rdata,
   output logic              dq_push,
   output logic              dq_pop,
   output logic [BYTE_W-1:0] dq_wbyte,
   input  logic [BYTE_W-1:0] dq_rbyte,
   input  logic              dq_empty,
   output logic              cq_push,
   output logic              cq_pop,
   output logic [BYTE_W-1:0] cq_wbyte,
   input  logic [BYTE_W-1:0] cq_rbyte,
   input  logic              cq_empty,
   output logic              tc_dec,
   input  logic              tc_zero
);

   logic              cmd_q;
   logic [HOST_W-1:0] wdata_q;
   logic [BYTE_W-1:0] wlane [WIDE_LANES];
   logic [BYTE_W-1:0] wbyte;
   logic              wr_go, rd_go, pop_go, src_empty;
   logic [BYTE_W-1:0] rbyte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         cmd_q   <= 1'b0;
         wdata_q <= '0;
      end else if (start) begin
         wr_q    <= wr_in;
         cmd_q   <= cmd_in;
         wdata_q <= wdata_in;
      end
   end

   for (genvar g = 0; g < WIDE_LANES; g++) begin : g_wlane
      assign wlane[g] = wdata_q[g*BYTE_W +: BYTE_W];
   end

   always_comb begin
      wbyte = '0;
      for (int i = 0; i < WIDE_LANES; i++) begin
         if (lane == IDX_W'(i)) wbyte = wlane[i];
      end
   end

   assign wr_go     = xfer & wr_q & ~tc_zero;
   assign dq_push   = wr_go & ~cmd_q;
   assign cq_push   = wr_go &  cmd_q;
   assign tc_dec    = wr_go;
   assign dq_wbyte  = wbyte;
   assign cq_wbyte  = wbyte;

   assign src_empty = cmd_q ? cq_empty : dq_empty;
   assign rd_go     = xfer & ~wr_q;
   assign pop_go    = rd_go & ~src_empty;
   assign dq_pop    = pop_go & ~cmd_q;
   assign cq_pop    = pop_go &  cmd_q;
   assign rbyte     = src_empty ? EMPTY_FILL : (cmd_q ? cq_rbyte : dq_rbyte);

   for (genvar g = 0; g < WIDE_LANES; g++) begin : g_rlane
      logic [BYTE_W-1:0] rl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                rl_q <= '0;
         else if (start)                            rl_q <= '0;
         else if (rd_go && (lane == IDX_W'(g)))     rl_q <= rbyte;
      end
      assign rdata[g*BYTE_W +: BYTE_W] = rl_q;
   end

endmodule

// File: rtl/pdma_lane_adapter.sv
module pdma_lane_adapter #(
   parameter int               BYTE_W        = 8,
   parameter int               WIDE_LANES    = 2,
   parameter int               SIZE_W        = 3,
   parameter int               MAX_ACC_BYTES = 4,
   parameter logic [BYTE_W-1:0] EMPTY_FILL   = '0,
   localparam int              HOST_W        = WIDE_LANES * BYTE_W,
   localparam int              IDX_W         = (WIDE_LANES > 1) ? $clog2(WIDE_LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_req,
   input  logic              acc_write,
   input  logic [SIZE_W-1:0] acc_size,
   input  logic [HOST_W-1:0] acc_wdata,
   output logic              acc_busy,
   output logic [HOST_W-1:0] acc_rdata,
   output logic              acc_rvalid,
   input  logic              cmd_phase,
   output logic              dq_push,
   output logic              dq_pop,
   output logic [BYTE_W-1:0] dq_wbyte,
   input  logic [BYTE_W-1:0] dq_rbyte,
   input  logic              dq_full,
   input  logic              dq_empty,
   output logic              cq_push,
   output logic              cq_pop,
   output logic [BYTE_W-1:0] cq_wbyte,
   input  logic [BYTE_W-1:0] cq_rbyte,
   input  logic              cq_empty,
   output logic              tc_dec,
   input  logic              tc_zero,
   output logic              xfer_done
);

   if (BYTE_W < 1) begin : g_bad_byte
      $error("BYTE_W must be at least 1");
   end
   if (WIDE_LANES < 1) begin : g_bad_lanes
      $error("WIDE_LANES must be at least 1");
   end
   if (WIDE_LANES > MAX_ACC_BYTES) begin : g_bad_max
      $error("WIDE_LANES cannot exceed MAX_ACC_BYTES");
   end
   if (MAX_ACC_BYTES >= (1 << SIZE_W)) begin : g_bad_size
      $error("SIZE_W too narrow for MAX_ACC_BYTES");
   end

   logic             size_ok;
   logic [IDX_W-1:0] first_lane;
   logic [IDX_W-1:0] lane;
   logic             start, xfer, check, wr_q;

   pdma_size_decode #(
      .SIZE_W(SIZE_W), .MAX_ACC_BYTES(MAX_ACC_BYTES),
      .WIDE_LANES(WIDE_LANES), .IDX_W(IDX_W)
   ) u_dec (
      .size(acc_size), .size_ok(size_ok), .first_lane(first_lane)
   );

   assign start = acc_req & ~acc_busy & size_ok;

   pdma_lane_seq #(.IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .first_lane(first_lane),
      .busy(acc_busy), .xfer(xfer), .check(check), .lane(lane)
   );

   pdma_byte_path #(
      .BYTE_W(BYTE_W), .WIDE_LANES(WIDE_LANES), .IDX_W(IDX_W),
      .EMPTY_FILL(EMPTY_FILL)
   ) u_path (
      .clk(clk), .rst_n(rst_n), .start(start), .xfer(xfer), .lane(lane),
      .wr_in(acc_write), .cmd_in(cmd_phase), .wdata_in(acc_wdata),
      .wr_q(wr_q), .rdata(acc_rdata),
      .dq_push(dq_push), .dq_pop(dq_pop), .dq_wbyte(dq_wbyte),
      .dq_rbyte(dq_rbyte), .dq_empty(dq_empty),
      .cq_push(cq_push), .cq_pop(cq_pop), .cq_wbyte(cq_wbyte),
      .cq_rbyte(cq_rbyte), .cq_empty(cq_empty),
      .tc_dec(tc_dec), .tc_zero(tc_zero)
   );

   assign acc_rvalid = check & ~wr_q;
   assign xfer_done  = check & (wr_q ? (tc_zero | dq_full) : dq_empty);

endmodule

// File: rtl/pdma_lane_adapter_chk.sv
module pdma_lane_adapter_chk (
   input logic clk,
   input logic rst_n,
   input logic acc_busy,
   input logic acc_rvalid,
   input logic xfer_done,
   input logic dq_push,
   input logic dq_pop,
   input logic dq_empty,
   input logic cq_push,
   input logic cq_pop,
   input logic cq_empty,
   input logic tc_dec,
   input logic tc_zero
);

   assert_queue_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !((dq_push | dq_pop) & (cq_push | cq_pop)));

   assert_dec_with_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_push | cq_push) |-> tc_dec);

   assert_no_dec_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tc_dec |-> !tc_zero);

   assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);

   assert_done_in_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> acc_busy);

   assert_dq_pop_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dq_pop |-> !dq_empty);

   assert_cq_pop_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cq_pop |-> !cq_empty);

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_busy |-> !(dq_push | dq_pop | cq_push | cq_pop | tc_dec | xfer_done | acc_rvalid));

   assert_rvalid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rvalid |=> !acc_rvalid);

endmodule

bind pdma_lane_adapter pdma_lane_adapter_chk chk_i (.*);

// File: tb/pdma_lane_adapter_tb_top.sv
module pdma_lane_adapter_tb_top;

   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_req = 1'b0, acc_write = 1'b0, cmd_phase = 1'b0;
   logic [2:0]  acc_size = 3'd0;
   logic [15:0] acc_wdata = 16'h0;
   logic        acc_busy, acc_rvalid, xfer_done;
   logic [15:0] acc_rdata;
   logic        dq_push, dq_pop, cq_push, cq_pop, tc_dec;
   logic [7:0]  dq_wbyte, cq_wbyte;
   logic [7:0]  dq_rbyte, cq_rbyte;
   logic        dq_full, dq_empty, cq_empty, tc_zero;

   int checks = 0;
   int errors = 0;

   logic [7:0] dq[$];
   logic [7:0] cq[$];
   int         tc = 0;

   always #2.5 clk = ~clk;

   pdma_lane_adapter dut_i (
      .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_write(acc_write),
      .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_busy(acc_busy),
      .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid), .cmd_phase(cmd_phase),
      .dq_push(dq_push), .dq_pop(dq_pop), .dq_wbyte(dq_wbyte),
      .dq_rbyte(dq_rbyte), .dq_full(dq_full), .dq_empty(dq_empty),
      .cq_push(cq_push), .cq_pop(cq_pop), .cq_wbyte(cq_wbyte),
      .cq_rbyte(cq_rbyte), .cq_empty(cq_empty),
      .tc_dec(tc_dec), .tc_zero(tc_zero), .xfer_done(xfer_done)
   );

   task automatic upd_flags();
      dq_full  = (dq.size() >= DEPTH);
      dq_empty = (dq.size() == 0);
      dq_rbyte = (dq.size() > 0) ? dq[0] : 8'h00;
      cq_empty = (cq.size() == 0);
      cq_rbyte = (cq.size() > 0) ? cq[0] : 8'h00;
      tc_zero  = (tc == 0);
   endtask

   always @(posedge clk) begin
      if (dq_push && dq.size() < DEPTH) dq.push_back(dq_wbyte);
      if (cq_push) cq.push_back(cq_wbyte);
      if (dq_pop && dq.size() > 0) void'(dq.pop_front());
      if (cq_pop && cq.size() > 0) void'(cq.pop_front());
      if (tc_dec && tc > 0) tc = tc - 1;
      upd_flags();
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic setup(input int n_tc, input int n_dq, input int n_cq);
      dq.delete(); cq.delete();
      for (int i = 0; i < n_dq; i++) dq.push_back(8'hC0 + 8'(i));
      for (int i = 0; i < n_cq; i++) cq.push_back(8'h50 + 8'(i));
      tc = n_tc;
      upd_flags();
   endtask

   int          n_done, done_at, n_rv, n_cyc;
   logic [15:0] rd;

   task automatic run_acc(input logic wr, input logic [2:0] sz, input logic [15:0] wd, input logic cmd);
      @(negedge clk);
      acc_req = 1'b1; acc_write = wr; acc_size = sz; acc_wdata = wd; cmd_phase = cmd;
      @(negedge clk);
      acc_req = 1'b0; cmd_phase = 1'b0;
      n_done = 0; done_at = -1; n_rv = 0; rd = 16'hxxxx; n_cyc = 0;
      for (int i = 0; i < 8 && acc_busy; i++) begin
         if (xfer_done) begin n_done++; done_at = i; end
         if (acc_rvalid) begin n_rv++; rd = acc_rdata; end
         n_cyc++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk(!acc_busy && !xfer_done && !acc_rvalid, "R12 idle outputs", {acc_busy, xfer_done, acc_rvalid}, 0);
      chk(!(dq_push|dq_pop|cq_push|cq_pop|tc_dec), "R12 strobes", {dq_push,dq_pop,cq_push,cq_pop,tc_dec}, 0);
   endtask

   task automatic t_write8();
      setup(5, 0, 0);
      run_acc(1'b1, 3'd1, 16'h77A5, 1'b0);
      chk(dq.size() == 1 && dq[0] == 8'hA5, "R8 byte write low lane", dq.size() ? dq[0] : -1, 'hA5);
      chk(tc == 4, "R3 one decrement", tc, 4);
      chk(n_done == 0, "R6 no done", n_done, 0);
   endtask

   task automatic t_write16();
      setup(6, 0, 0);
      run_acc(1'b1, 3'd2, 16'h1234, 1'b0);
      chk(dq.size() == 2 && dq[0] == 8'h12 && dq[1] == 8'h34, "R1 high byte first",
          dq.size() == 2 ? {dq[0], dq[1]} : -1, 'h1234);
      chk(tc == 4, "R3 two decrements", tc, 4);
      chk(n_cyc == 3, "R11 busy length", n_cyc, 3);
   endtask

   task automatic t_write_tc_zero();
      setup(1, 0, 0);
      run_acc(1'b1, 3'd2, 16'hBEEF, 1'b0);
      chk(dq.size() == 1 && dq[0] == 8'hBE, "R4 second byte dropped", dq.size(), 1);
      chk(tc == 0, "R4 counter stays zero", tc, 0);
      chk(n_done == 1 && done_at == 2, "R6 R11 done on zero", done_at, 2);
   endtask

   task automatic t_write_full();
      setup(100, DEPTH - 2, 0);
      run_acc(1'b1, 3'd2, 16'h0102, 1'b0);
      chk(n_done == 1, "R6 done on full", n_done, 1);
      setup(100, DEPTH - 4, 0);
      run_acc(1'b1, 3'd2, 16'h0102, 1'b0);
      chk(n_done == 0, "R6 no done below full", n_done, 0);
   endtask

   task automatic t_read16();
      setup(0, 2, 0);
      dq[0] = 8'h9A; dq[1] = 8'hBC; upd_flags();
      run_acc(1'b0, 3'd2, 16'h0, 1'b0);
      chk(n_rv == 1 && rd == 16'h9ABC, "R2 read assembly", rd, 'h9ABC);
      chk(n_done == 1 && done_at == 2, "R7 done on empty", done_at, 2);
   endtask

   task automatic t_read8_more();
      setup(0, 3, 0);
      run_acc(1'b0, 3'd1, 16'h0, 1'b0);
      chk(rd == 16'h00C0, "R8 byte read zero upper", rd, 'h00C0);
      chk(n_done == 0 && dq.size() == 2, "R7 no done with data left", n_done, 0);
   endtask

   task automatic t_read_empty();
      setup(0, 0, 0);
      run_acc(1'b0, 3'd2, 16'h0, 1'b0);
      chk(rd == 16'h0000, "R10 empty reads zero", rd, 0);
      chk(n_done == 1 && done_at == 2, "R7 R11 done empty", done_at, 2);
      setup(0, 1, 0);
      run_acc(1'b0, 3'd2, 16'h0, 1'b0);
      chk(rd == 16'hC000, "R10 second byte empty fill", rd, 'hC000);
   endtask

   task automatic t_cmd_write();
      setup(9, 1, 0);
      run_acc(1'b1, 3'd2, 16'h3C4D, 1'b1);
      chk(cq.size() == 2 && cq[0] == 8'h3C && cq[1] == 8'h4D, "R5 cmd queue write",
          cq.size() == 2 ? {cq[0], cq[1]} : -1, 'h3C4D);
      chk(dq.size() == 1 && tc == 7, "R5 data queue untouched", dq.size(), 1);
   endtask

   task automatic t_cmd_read();
      setup(0, 1, 2);
      run_acc(1'b0, 3'd2, 16'h0, 1'b1);
      chk(rd == 16'h5051, "R5 cmd queue read", rd, 'h5051);
      chk(n_done == 0 && dq.size() == 1, "R7 cmd read done uses data queue", n_done, 0);
   endtask

   task automatic t_sizes();
      setup(8, 0, 0);
      run_acc(1'b1, 3'd4, 16'h3344, 1'b0);
      chk(dq.size() == 2 && dq[0] == 8'h33 && dq[1] == 8'h44, "R8 size 4 as 2",
          dq.size() == 2 ? {dq[0], dq[1]} : -1, 'h3344);
      setup(8, 0, 0);
      run_acc(1'b1, 3'd3, 16'h5566, 1'b0);
      chk(dq.size() == 2 && tc == 6, "R8 size 3 as 2", dq.size(), 2);
      setup(8, 0, 0);
      run_acc(1'b1, 3'd0, 16'h7788, 1'b0);
      chk(n_cyc == 0 && dq.size() == 0 && tc == 8, "R9 size 0 ignored", dq.size(), 0);
      run_acc(1'b1, 3'd5, 16'h7788, 1'b0);
      chk(n_cyc == 0 && dq.size() == 0 && tc == 8, "R9 size 5 ignored", dq.size(), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      setup(0, 0, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write8();
      t_write16();
      t_write_tc_zero();
      t_write_full();
      t_read16();
      t_read8_more();
      t_read_empty();
      t_cmd_write();
      t_cmd_read();
      t_sizes();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule